// File: doc/BRIEF.md
# Sixteen-Opcode Data-Processing ALU

This block is the integer arithmetic and logic stage of a 32-bit load/store processor. It accepts a 4-bit operation code and two operands. The second operand is either a register value or an 8-bit constant rotated right by twice a 4-bit rotate amount. The block produces a registered result, a destination write-enable and the four condition flags: negative, zero, carry and overflow.

The operations are bitwise logic, move, add and subtract in both directions, carry-chained forms of add and subtract, and four compare/test operations. The compare/test operations only refresh the flags. The carry flag comes from the surrounding status register. A separate shifter-carry input supplies the carry for logical operations.

Each operation issued with the input strobe completes one clock later, and the output strobe marks that cycle. The flags are held inside the block. They change only when an operation completes.

Top module: `dp_alu`

## Requirements
- R1: The logical operation codes compute these results from operand A and the second operand B: 0 = A AND B, 1 = A XOR B, 12 = A OR B, 13 = B, 14 = A AND NOT B, 15 = NOT B.
- R2: Code 4 gives A+B, code 2 gives A-B and code 3 gives B-A. Carry is the adder carry-out, so for subtraction it is 1 when no borrow occurs. Overflow is set when the signed result does not fit in 32 bits.
- R3: Code 5 gives A+B+carry_in. Code 6 gives A-B-(1-carry_in). Code 7 gives B-A-(1-carry_in). Carry and overflow follow the same meaning as in R2.
- R4: Codes 8 (test, AND), 9 (test-equal, XOR), 10 (compare, A-B) and 11 (compare-negative, A+B) update all four flags as their operation would. They never assert wr_en.
- R5: When imm_sel is 1, B is imm_val zero-extended to 32 bits and rotated right by 2*imm_rot, and src_b is ignored. A rotate amount of 0 passes the constant unchanged.
- R6: For the logical codes (0, 1, 8, 9, 12 to 15), the carry flag takes shift_carry and the overflow flag keeps its previous value.
- R7: flag_n equals bit 31 of the computed value. flag_z is 1 exactly when the computed value is zero.
- R8: out_valid is asserted in the cycle after in_valid. wr_en can be 1 only while out_valid is 1, and result holds the computed value in that cycle.
- R9: A synchronous active-high reset clears all four flags, out_valid, wr_en and result.
- R10: In a cycle without in_valid, out_valid and wr_en are 0, and the result and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| opcode | input | 4 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Register second operand |
| imm_sel | input | 1 | 1 selects the rotated immediate as second operand |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate amount, in units of two bits |
| carry_in | input | 1 | Current carry flag from the status register |
| shift_carry | input | 1 | Carry produced by the operand shifter |
| out_valid | output | 1 | Result and flags are updated this cycle |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination register write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench checks the borrow polarity on equal and unequal operands for subtract-with-carry in both directions. A design that used carry_in directly as the borrow would be off by one in the result and would report the wrong carry. It also checks the signed overflow boundaries 0x7FFFFFFF+1 and 0x80000000-1, where a wrong sign test leaves overflow clear. For immediate rotation it uses amounts 0, 1, 4 and 15: a rotate that shifts instead of wrapping loses bits at amount 1 and amount 15. After the overflow flag has been set, the bench runs logical operations and compare operations, so that a design that clears overflow or writes on a compare is caught.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 8;
    localparam int ROT_W  = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_is_compare(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_logic(alu_op_e op);
        case (op)
            OP_AND, OP_XOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp_operand_sel.sv
module dp_operand_sel
    import dp_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int IW    = IMM_W,
    parameter int RW    = ROT_W
) (
    input  logic [W-1:0]  reg_opnd,
    input  logic          use_imm,
    input  logic [IW-1:0] imm,
    input  logic [RW-1:0] rot,
    output logic [W-1:0]  opnd_b
);
    localparam int AMT_W = RW + 1;

    logic [W-1:0]   imm_ext;
    logic [AMT_W-1:0] amount;
    logic [2*W-1:0] doubled;

    always_comb begin
        imm_ext = W'(imm);
        amount  = {rot, 1'b0};
        // rotating right equals shifting a doubled copy and keeping the low half
        doubled = {imm_ext, imm_ext} >> amount;
        opnd_b  = use_imm ? doubled[W-1:0] : reg_opnd;
    end
endmodule

// File: rtl/dp_arith_core.sv
module dp_arith_core
    import dp_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e     op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic        carry_in,
    input  logic        shift_carry,
    input  logic        v_prev,
    output logic [W-1:0] value,
    output alu_flags_t  flags,
    output logic        writes
);
    logic [W-1:0] add_x, add_y;
    logic         add_cin;
    logic [W:0]   sum;
    logic         arith;

    // one adder serves every arithmetic code: swap and invert inputs instead
    always_comb begin
        add_x   = a;
        add_y   = b;
        add_cin = 1'b0;
        case (op)
            OP_ADD, OP_CMN: begin add_x = a; add_y = b;  add_cin = 1'b0;     end
            OP_ADC:         begin add_x = a; add_y = b;  add_cin = carry_in; end
            OP_SUB, OP_CMP: begin add_x = a; add_y = ~b; add_cin = 1'b1;     end
            OP_SBC:         begin add_x = a; add_y = ~b; add_cin = carry_in; end
            OP_RSB:         begin add_x = b; add_y = ~a; add_cin = 1'b1;     end
            OP_RSC:         begin add_x = b; add_y = ~a; add_cin = carry_in; end
            default:        begin add_x = a; add_y = b;  add_cin = 1'b0;     end
        endcase
        sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
    end

    always_comb begin
        arith = !op_is_logic(op);
        case (op)
            OP_AND, OP_TST: value = a & b;
            OP_XOR, OP_TEQ: value = a ^ b;
            OP_ORR:         value = a | b;
            OP_MOV:         value = b;
            OP_BIC:         value = a & ~b;
            OP_MVN:         value = ~b;
            default:        value = sum[W-1:0];
        endcase
        flags.n = value[W-1];
        flags.z = (value == '0);
        if (arith) begin
            flags.c = sum[W];
            flags.v = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);
        end else begin
            flags.c = shift_carry;
            flags.v = v_prev;
        end
        writes = !op_is_compare(op);
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W,
    parameter int RW = ROT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    opcode,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic          imm_sel,
    input  logic [IW-1:0] imm_val,
    input  logic [RW-1:0] imm_rot,
    input  logic          carry_in,
    input  logic          shift_carry,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic          wr_en,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v
);
    alu_op_e    op;
    logic [W-1:0] opnd_b;
    logic [W-1:0] next_value;
    alu_flags_t next_flags;
    logic       next_writes;

    alu_flags_t flags_q;
    logic [W-1:0] result_q;
    logic       valid_q;
    logic       wr_q;

    assign op = alu_op_e'(opcode);

    dp_operand_sel #(.W(W), .IW(IW), .RW(RW)) opsel_i (
        .reg_opnd (src_b),
        .use_imm  (imm_sel),
        .imm      (imm_val),
        .rot      (imm_rot),
        .opnd_b   (opnd_b)
    );

    dp_arith_core #(.W(W)) core_i (
        .op          (op),
        .a           (src_a),
        .b           (opnd_b),
        .carry_in    (carry_in),
        .shift_carry (shift_carry),
        .v_prev      (flags_q.v),
        .value       (next_value),
        .flags       (next_flags),
        .writes      (next_writes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            valid_q <= in_valid;
            wr_q    <= in_valid && next_writes;
            if (in_valid) begin
                flags_q  <= next_flags;
                result_q <= next_value;
            end
        end
    end

    assign out_valid = valid_q;
    assign result    = result_q;
    assign wr_en     = wr_q;
    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
    assign flag_v    = flags_q.v;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !wr_en); // R8
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[3:2] == 2'b10) |=> !wr_en); // R4
    AST_LOGIC_V_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_logic(op)) |=> $stable(flag_v)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flags_q) && !out_valid)); // R10
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_z == (result == '0) && flag_n == result[W-1])); // R7
endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  opcode;
    logic [31:0] src_a, src_b;
    logic        imm_sel;
    logic [7:0]  imm_val;
    logic [3:0]  imm_rot;
    logic        carry_in, shift_carry;
    logic        out_valid, wr_en, flag_n, flag_z, flag_c, flag_v;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    logic pv = 1'b0;  // bench copy of the overflow flag

    always #5 clk = ~clk;

    dp_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .imm_sel(imm_sel), .imm_val(imm_val),
        .imm_rot(imm_rot), .carry_in(carry_in), .shift_carry(shift_carry),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rot_imm(input logic [7:0] v, input logic [3:0] r);
        logic [31:0] x = {24'd0, v};
        for (int i = 0; i < 2 * r; i++) x = {x[0], x[31:1]};
        return x;
    endfunction

    function automatic logic ovf(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic sc,
                         output logic [31:0] r, output logic [3:0] nzcv, output logic we);
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint bw = ci ? 64'sd0 : 64'sd1;
        longint full = 0;
        logic c = sc;
        logic v = pv;
        case (op)
            4'd0, 4'd8:  r = a & b;
            4'd1, 4'd9:  r = a ^ b;
            4'd12:       r = a | b;
            4'd13:       r = b;
            4'd14:       r = a & ~b;
            4'd15:       r = ~b;
            4'd4, 4'd11: begin full = ua + ub;      c = full > 64'sh0FFFFFFFF; v = ovf(sa + sb); end
            4'd5:        begin full = ua + ub + (ci ? 64'sd1 : 64'sd0);
                               c = full > 64'sh0FFFFFFFF; v = ovf(sa + sb + (ci ? 64'sd1 : 64'sd0)); end
            4'd2, 4'd10: begin full = ua - ub;      c = full >= 0; v = ovf(sa - sb); end
            4'd6:        begin full = ua - ub - bw; c = full >= 0; v = ovf(sa - sb - bw); end
            4'd3:        begin full = ub - ua;      c = full >= 0; v = ovf(sb - sa); end
            default:     begin full = ub - ua - bw; c = full >= 0; v = ovf(sb - sa - bw); end
        endcase
        if (!(op inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
            r = full[31:0];
        nzcv = {r[31], r == 32'd0, c, v};
        we = !(op inside {4'd8, 4'd9, 4'd10, 4'd11});
    endtask

    // issue one operation and check it in the following cycle
    task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] breg, input logic isel, input logic [7:0] iv,
                       input logic [3:0] ir, input logic ci, input logic sc);
        logic [31:0] r;
        logic [3:0]  nzcv;
        logic        we;
        model(op, a, isel ? rot_imm(iv, ir) : breg, ci, sc, r, nzcv, we);
        @(negedge clk);
        opcode = op; src_a = a; src_b = breg; imm_sel = isel; imm_val = iv;
        imm_rot = ir; carry_in = ci; shift_carry = sc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", {31'd0, out_valid}, 32'd1);
        check(tag, "result", result, r);
        check(tag, "wr_en", {31'd0, wr_en}, {31'd0, we});
        check(tag, "nzcv", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, nzcv});
        pv = nzcv[0];
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pv = 1'b0;
        check("R9", "flags after reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        check("R9", "out_valid/wr_en after reset", {30'd0, out_valid, wr_en}, 32'd0);
        check("R9", "result after reset", result, 32'd0);
    endtask

    task automatic t_logic();
        run("R1", 4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
        run("R1", 4'd1,  32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 0, 1, 1);
        run("R1", 4'd12, 32'h1200_0034, 32'h0056_7800, 0, 0, 0, 0, 0);
        run("R1", 4'd13, 32'h1111_1111, 32'h8000_0000, 0, 0, 0, 0, 1);
        run("R1", 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 0, 0, 0);
        run("R7", 4'd15, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);     // zero result
    endtask

    task automatic t_arith();
        run("R2", 4'd4, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);       // carry out, zero
        run("R2", 4'd4, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);       // signed overflow
        run("R6", 4'd0, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0, 0, 1); // V held, C=shift
        run("R6", 4'd8, 32'h0000_00FF, 32'h0000_FF00, 0, 0, 0, 0, 0); // test keeps V
        run("R2", 4'd2, 32'h5, 32'h7, 0, 0, 0, 1, 0);               // borrow
        run("R2", 4'd2, 32'h8000_0000, 32'h1, 0, 0, 0, 0, 0);       // overflow on subtract
        run("R2", 4'd3, 32'h5, 32'h7, 0, 0, 0, 0, 0);               // reverse
        run("R2", 4'd2, 32'h9, 32'h9, 0, 0, 0, 0, 0);               // equal: C=1, Z=1
    endtask

    task automatic t_carry();
        run("R3", 4'd5, 32'h10, 32'h20, 0, 0, 0, 0, 0);
        run("R3", 4'd5, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 1, 0);
        run("R3", 4'd6, 32'h9, 32'h9, 0, 0, 0, 1, 0);               // no borrow in
        run("R3", 4'd6, 32'h9, 32'h9, 0, 0, 0, 0, 0);               // borrow in
        run("R3", 4'd7, 32'h3, 32'h3, 0, 0, 0, 0, 0);
        run("R3", 4'd7, 32'h3, 32'h10, 0, 0, 0, 1, 0);
    endtask

    task automatic t_compare();
        run("R4", 4'd8,  32'hF0, 32'h0F, 0, 0, 0, 0, 1);
        run("R4", 4'd9,  32'h1234, 32'h1234, 0, 0, 0, 0, 0);
        run("R4", 4'd10, 32'h1, 32'h2, 0, 0, 0, 0, 0);
        run("R4", 4'd11, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);
    endtask

    task automatic t_imm();
        run("R5", 4'd13, 32'h0, 32'hDEAD_BEEF, 1, 8'hFF, 4'd0, 0, 0);
        run("R5", 4'd13, 32'h0, 32'hDEAD_BEEF, 1, 8'hFF, 4'd1, 0, 0);
        run("R5", 4'd13, 32'h0, 32'h0, 1, 8'hFF, 4'd4, 0, 0);
        run("R5", 4'd4,  32'h1, 32'h5555_5555, 1, 8'hFF, 4'd15, 0, 0);
        check("R5", "rotate 0 constant", rot_imm(8'hFF, 4'd0), 32'h0000_00FF);
    endtask

    task automatic t_hold();
        logic [31:0] r_keep;
        logic [3:0]  f_keep;
        run("R8", 4'd2, 32'h0, 32'h1, 0, 0, 0, 0, 0);
        r_keep = result;
        f_keep = {flag_n, flag_z, flag_c, flag_v};
        src_a = 32'h1234_5678; opcode = 4'd4;   // inputs move without a strobe
        @(negedge clk);
        check("R10", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check("R8", "wr_en idle", {31'd0, wr_en}, 32'd0);
        check("R10", "result held", result, r_keep);
        check("R10", "flags held", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, f_keep});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; opcode = 4'd0; src_a = '0; src_b = '0;
        imm_sel = 1'b0; imm_val = '0; imm_rot = '0; carry_in = 1'b0; shift_carry = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_logic();
        t_arith();
        t_carry();
        t_compare();
        t_imm();
        t_hold();
        run("R9", 4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);  // set N and V
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule